// File: doc/BRIEF.md
# Modem Line Status and Control Unit

This block serves the modem-handshake side of one asynchronous serial channel. It watches four active-low modem pins (clear-to-send, data-set-ready, ring indicator, carrier detect). Each pin passes through a synchronizer chain. The unit then shows, in an 8-bit status word, which lines are asserted and which have changed since the host last read that word. The change flags are sticky. A status read returns them as they stood and clears them at the same clock edge. A change that is detected in the cycle of that read is still recorded.

The host also writes a control word. One bit drives the active-low data-terminal-ready output and another drives the active-low request-to-send output. A third bit enables an interrupt request, which is raised while any change flag is set. Carrier detect is reported only through the status word and the interrupt, and it has no path into any receive logic or output pin. The serial shifter, the FIFOs and the baud timing sit elsewhere in the channel.

Top module: `modem_line_ctl`

## Requirements
- R1: While reset (synchronous, active low) is applied, and with all modem pins held high, the status word reads 0x00 and the control word reads 0x00. Both dtr_n_o and rts_n_o are 1, and msi_irq_o is 0.
- R2: Status bits 4, 5, 6 and 7 show the asserted (pin low = 1) state of CTS, DSR, RI and DCD in that order. A pin change becomes visible after SYNC_STAGES clock edges.
- R3: Status bit 0 (CTS), bit 1 (DSR) and bit 3 (DCD) become 1 one edge after the matching level bit changes in either direction.
- R4: Status bit 2 becomes 1 only when the RI pin goes from low to high, which is the end of a ring and shows as bit 6 falling. A falling RI pin does not set it.
- R5: While no status read happens, a set change flag stays set.
- R6: During a read cycle (stat_rd_i = 1) the status word shows the flags as they were. After that edge, bits 0 to 3 are cleared and bits 4 to 7 are unchanged.
- R7: A change detected at the same edge as a status read leaves its flag set after that read.
- R8: A control write (ctl_wr_i = 1) stores bits 0, 1 and 3 of ctl_wd_i. The other bits read back as 0 on ctl_q_o and have no effect. Without a write, the control word holds its value.
- R9: dtr_n_o is the inverse of control bit 0 and rts_n_o is the inverse of control bit 1, both updated one edge after the write.
- R10: msi_irq_o is 1 exactly when control bit 3 is 1 and at least one of status bits 0 to 3 is 1.
- R11: A DCD change alters only status bits 3 and 7 (and through them msi_irq_o). It leaves the other status bits, dtr_n_o and rts_n_o untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_i | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier detect pin, active low, asynchronous |
| stat_rd_i | input | 1 | Status read strobe; clears change flags at the edge |
| stat_q_o | output | 8 | Status word: flags in bits 3:0, levels in bits 7:4 |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_wd_i | input | 8 | Control write data |
| ctl_q_o | output | 8 | Control word readback |
| dtr_n_o | output | 1 | Data-terminal-ready, active low |
| rts_n_o | output | 1 | Request-to-send, active low |
| msi_irq_o | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the unit with SYNC_STAGES set to 3 rather than the default 2. This runs the synchronizer loop beyond its minimum length and shifts every pin-to-flag latency by one edge, so a model with a hard-coded two-edge delay would fail. With that depth, the bench times a pin change so that its flag arrives at exactly the edge of a status read, which is the collision case. It also confirms that a ring pin falling is ignored and that only its release sets the ring flag.

// File: rtl/mdm_pkg.sv
`timescale 1ns/1ps
// Package mdm_pkg
// Shared constants for the modem line unit: line indices (these also set the
// order of the status bits) and the control word field positions.
package mdm_pkg;
    localparam int NLINES   = 4;
    localparam int LN_CTS   = 0;
    localparam int LN_DSR   = 1;
    localparam int LN_RI    = 2;
    localparam int LN_DCD   = 3;
    localparam int CTL_W    = 8;
    localparam int CTL_DTR  = 0;
    localparam int CTL_RTS  = 1;
    localparam int CTL_MSIE = 3;
    localparam logic [CTL_W-1:0] CTL_MASK =
        CTL_W'((1 << CTL_DTR) | (1 << CTL_RTS) | (1 << CTL_MSIE));
    // Lines whose flag fires only on a rising pin (end of ring)
    localparam logic [NLINES-1:0] RISE_ONLY = NLINES'(1 << LN_RI);
endpackage

// File: rtl/mdm_sync.sv
`timescale 1ns/1ps
// Module mdm_sync
// Multi-flop synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; no bus coherency is implied.
// Reset value is RST_VAL so that idle-high pins produce no spurious edge.
module mdm_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_q;

    // Shift the pin vector through STAGES flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) begin
                chain_q[k] <= chain_q[k-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

    initial begin
        AST_SYNC_DEPTH: assert (STAGES >= 2); // R2
    end
endmodule

// File: rtl/mdm_delta.sv
`timescale 1ns/1ps
// Module mdm_delta
// Change detection and sticky change flags for the synchronized modem pins.
// Assumes pin_s_i is already synchronous. Lines marked in RISE_ONLY flag only
// a low-to-high pin transition; the others flag either direction.
// clr_i clears the flags at the edge, but an event at that edge survives.
module mdm_delta
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] pin_s_i,
    input  logic              clr_i,
    output logic [NLINES-1:0] lvl_o,
    output logic [NLINES-1:0] flg_o
);
    logic [NLINES-1:0] prev_q;
    logic [NLINES-1:0] flg_q;
    logic [NLINES-1:0] evt;

    // Per-line event: rising pin only, or any change
    for (genvar i = 0; i < NLINES; i++) begin : g_evt
        if (RISE_ONLY[i]) begin : g_rise
            assign evt[i] = pin_s_i[i] & ~prev_q[i];
        end else begin : g_any
            assign evt[i] = pin_s_i[i] ^ prev_q[i];
        end
    end

    // Remember last synchronized pin state
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= pin_s_i;
    end

    // Sticky flags: read clears, new event wins over the clear
    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= (clr_i ? '0 : flg_q) | evt;
    end

    assign lvl_o = ~pin_s_i;
    assign flg_o = flg_q;

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flg_q & $past(flg_q)) == $past(flg_q))); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (evt == '0)) |=> (flg_q == '0)); // R6
    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flg_q & $past(evt)) == $past(evt))); // R7
endmodule

// File: rtl/mdm_ctrl.sv
`timescale 1ns/1ps
// Module mdm_ctrl
// Control word register and the active-low handshake outputs it drives.
// Assumes a single-cycle write strobe; bits outside CTL_MASK are dropped.
module mdm_ctrl
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] wd_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic             dtr_n_o,
    output logic             rts_n_o
);
    logic [CTL_W-1:0] ctl_q;

    // Store implemented control bits on a write
    always_ff @(posedge clk) begin
        if (!rst_n)    ctl_q <= '0;
        else if (wr_i) ctl_q <= wd_i & CTL_MASK;
    end

    assign ctl_o   = ctl_q;
    assign dtr_n_o = ~ctl_q[CTL_DTR];
    assign rts_n_o = ~ctl_q[CTL_RTS];

    AST_DTR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (dtr_n_o == !$past(wd_i[CTL_DTR]))); // R9
    AST_CTL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(ctl_q)); // R8
endmodule

// File: rtl/modem_line_ctl.sv
`timescale 1ns/1ps
// Module modem_line_ctl
// Modem-line status and control for one serial channel. Synchronizes four
// active-low modem pins, builds the status word {levels, flags}, holds the
// control word and raises an enabled modem-status interrupt.
// Assumes stat_rd_i is one cycle per host read; DCD feeds no receive logic.
module modem_line_ctl
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_n_i,
    input  logic       dsr_n_i,
    input  logic       ri_n_i,
    input  logic       dcd_n_i,
    input  logic       stat_rd_i,
    output logic [7:0] stat_q_o,
    input  logic       ctl_wr_i,
    input  logic [7:0] ctl_wd_i,
    output logic [7:0] ctl_q_o,
    output logic       dtr_n_o,
    output logic       rts_n_o,
    output logic       msi_irq_o
);
    logic [NLINES-1:0] pins_raw;
    logic [NLINES-1:0] pins_s;
    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] flg;
    logic [CTL_W-1:0]  ctl;

    // Gather pins in line-index order
    always_comb begin
        pins_raw         = '1;
        pins_raw[LN_CTS] = cts_n_i;
        pins_raw[LN_DSR] = dsr_n_i;
        pins_raw[LN_RI]  = ri_n_i;
        pins_raw[LN_DCD] = dcd_n_i;
    end

    mdm_sync #(.W(NLINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    mdm_delta u_delta (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_s_i (pins_s),
        .clr_i   (stat_rd_i),
        .lvl_o   (lvl),
        .flg_o   (flg)
    );

    mdm_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr_i),
        .wd_i    (ctl_wd_i),
        .ctl_o   (ctl),
        .dtr_n_o (dtr_n_o),
        .rts_n_o (rts_n_o)
    );

    // Assemble status word and interrupt
    always_comb begin
        stat_q_o  = {lvl, flg};
        ctl_q_o   = ctl;
        msi_irq_o = ctl[CTL_MSIE] & (|flg);
    end

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        msi_irq_o |-> (stat_q_o[3:0] != 4'h0)); // R10
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        msi_irq_o |-> ctl_q_o[CTL_MSIE]); // R10
endmodule

// File: tb/tb_modem_line_ctl.sv
`timescale 1ns/1ps
module tb_modem_line_ctl;
    localparam int STG = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] pins;              // index: 0 cts, 1 dsr, 2 ri, 3 dcd
    logic       rd, wr;
    logic [7:0] wd;
    logic [7:0] stat_q, ctl_q;
    logic       dtr_n, rts_n, irq;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [3:0] mpipe [STG];
    logic [3:0] mprev;
    logic [3:0] mflg;
    logic [7:0] mctl;

    always #2.5 clk = ~clk;

    modem_line_ctl #(.SYNC_STAGES(STG)) dut (
        .clk(clk), .rst_n(rst_n),
        .cts_n_i(pins[0]), .dsr_n_i(pins[1]), .ri_n_i(pins[2]), .dcd_n_i(pins[3]),
        .stat_rd_i(rd), .stat_q_o(stat_q),
        .ctl_wr_i(wr), .ctl_wd_i(wd), .ctl_q_o(ctl_q),
        .dtr_n_o(dtr_n), .rts_n_o(rts_n), .msi_irq_o(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_stat();
        return {~mpipe[STG-1], mflg};
    endfunction

    function automatic logic exp_irq();
        return mctl[3] & (|mflg);
    endfunction

    task automatic model_reset();
        for (int k = 0; k < STG; k++) mpipe[k] = 4'hF;
        mprev = 4'hF;
        mflg  = 4'h0;
        mctl  = 8'h00;
    endtask

    // model of one clock edge with the inputs just driven
    task automatic model_step();
        logic [3:0] s, evt;
        s      = mpipe[STG-1];
        evt    = s ^ mprev;
        evt[2] = s[2] & ~mprev[2];
        mflg   = (rd ? 4'h0 : mflg) | evt;
        mprev  = s;
        for (int k = STG-1; k > 0; k--) mpipe[k] = mpipe[k-1];
        mpipe[0] = pins;
        if (wr) mctl = wd & 8'h0B;
    endtask

    task automatic chk_all();
        logic [7:0] e;
        e = exp_stat();
        chk("R2 levels",     {4'h0, stat_q[7:4]}, {4'h0, e[7:4]});
        chk("R3 cts/dsr/dcd flags", {5'h0, stat_q[3], stat_q[1:0]}, {5'h0, e[3], e[1:0]});
        chk("R4 ring flag",  {7'h0, stat_q[2]}, {7'h0, e[2]});
        chk("R8 ctl readback", ctl_q, mctl);
        chk("R9 dtr_n",      {7'h0, dtr_n}, {7'h0, ~mctl[0]});
        chk("R9 rts_n",      {7'h0, rts_n}, {7'h0, ~mctl[1]});
        chk("R10 irq",       {7'h0, irq},   {7'h0, exp_irq()});
    endtask

    // check at negedge, then drive the inputs for the coming edge
    task automatic step(input logic [3:0] p, input logic r, input logic w, input logic [7:0] d);
        @(negedge clk);
        chk_all();
        pins = p; rd = r; wr = w; wd = d;
        model_step();
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] snap;
        logic [3:0] p;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; pins = 4'hF; rd = 0; wr = 0; wd = 8'h00;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 reset status", stat_q, 8'h00);
        chk("R1 reset ctl",    ctl_q,  8'h00);
        chk("R1 reset pins",   {5'h0, dtr_n, rts_n, irq}, 8'h06);
        rst_n = 1'b1;

        // R2/R3: assert CTS, watch level then flag
        step(4'b1110, 0, 0, 8'h00);
        repeat (STG + 2) step(4'b1110, 0, 0, 8'h00);
        chk("R2 cts level", {7'h0, stat_q[4]}, 8'h01);
        chk("R3 cts flag",  {7'h0, stat_q[0]}, 8'h01);
        // R5: no read, flag holds
        repeat (5) step(4'b1110, 0, 0, 8'h00);
        chk("R5 flag sticky", {7'h0, stat_q[0]}, 8'h01);
        // R6: read returns old value, clears afterwards
        step(4'b1110, 1, 0, 8'h00);
        chk("R6 read returns flags", stat_q, 8'h11);
        step(4'b1110, 0, 0, 8'h00);
        chk("R6 cleared after read", stat_q, 8'h10);

        // R4: ring asserted (pin falls) sets no flag; release sets it
        repeat (STG + 2) step(4'b1010, 0, 0, 8'h00);
        chk("R4 falling ri no flag", {7'h0, stat_q[2]}, 8'h00);
        chk("R4 ri level", {7'h0, stat_q[6]}, 8'h01);
        repeat (STG + 2) step(4'b1110, 0, 0, 8'h00);
        chk("R4 rising ri flag", {7'h0, stat_q[2]}, 8'h01);
        step(4'b1110, 1, 0, 8'h00);

        // R7: DSR change whose flag lands on the read edge
        step(4'b1100, 0, 0, 8'h00);
        for (int j = 1; j < STG; j++) step(4'b1100, 0, 0, 8'h00);
        step(4'b1100, 1, 0, 8'h00);
        step(4'b1100, 0, 0, 8'h00);
        chk("R7 change kept across read", {7'h0, stat_q[1]}, 8'h01);
        step(4'b1100, 1, 0, 8'h00);

        // R8/R9/R10: write all ones, only implemented bits stick
        step(4'b1100, 0, 1, 8'hFF);
        step(4'b1100, 0, 0, 8'h00);
        chk("R8 ignored bits", ctl_q, 8'h0B);
        chk("R9 outputs low", {6'h0, dtr_n, rts_n}, 8'h00);
        chk("R10 irq clear w/o flag", {7'h0, irq}, 8'h00);

        // R11: toggle DCD only
        snap = stat_q;
        repeat (STG + 2) step(4'b0100, 0, 0, 8'h00);
        chk("R11 other bits", {stat_q[6:4], stat_q[2:0]}, {snap[6:4], snap[2:0]});
        chk("R11 dcd bits", {stat_q[7], stat_q[3]}, 8'h03);
        chk("R11 dtr/rts", {6'h0, dtr_n, rts_n}, 8'h00);
        chk("R10 irq on dcd flag", {7'h0, irq}, 8'h01);

        // constrained random
        p = 4'b0100;
        for (int n = 0; n < 3000; n++) begin
            for (int b = 0; b < 4; b++)
                if ($urandom_range(0, 7) == 0) p[b] = ~p[b];
            step(p, ($urandom_range(0, 5) == 0), ($urandom_range(0, 9) == 0),
                 8'($urandom));
        end
        step(p, 0, 0, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule